// File: doc/BRIEF.md
# Selectable PCM Line Code Encoder

This block takes a serial data stream, one bit per strobe, and puts it on a single line in one of nine PCM line codes. The codes fall into four families: level codes (NRZ-L, NRZ-M, NRZ-S), split-phase codes (BIO-L, BIO-M, BIO-S), delay-modulation codes (DM-M, DM-S) and a randomized level code (RNRZ-L). The block runs from a clock at twice the bit rate, so every bit period has two half-bit slots. Codes with a transition in the middle of the bit use both slots.

An upstream serializer pulses `bit_stb` for one clock with the next bit on `bit_in`. The 4-bit `code_sel` value picks the code. It is usually held constant from stored configuration, which is loaded at power-up and again after reprogramming. The block also produces `bit_clk`, a bit-rate clock that is high during the first half of each bit on the line.

The control is a three-state machine.
- `ST_IDLE`: no bit is in progress and the line holds its level.
- `ST_FIRST`: the first half of a bit is on the line.
- `ST_SECOND`: the second half of a bit is on the line.

Its transitions are:
- `ST_IDLE -> ST_FIRST` on an accepted strobe.
- `ST_FIRST -> ST_SECOND` always.
- `ST_SECOND -> ST_FIRST` on an accepted strobe, which gives back-to-back bits.
- `ST_SECOND -> ST_IDLE` when no strobe is present.
- `ST_IDLE -> ST_IDLE` when no strobe is present.

Top module: `pcm_line_encoder`

## Requirements
- R1: While `rst_n` is low, and after it is released, `line_out` is 0 and `bit_clk` is 0 until the first strobe is accepted. The randomizer is set to all ones, and the delay-modulation history is set as if the previous bit had been 1 (mark).
- R2: A strobe is accepted when the state is not `ST_FIRST`; a strobe seen in `ST_FIRST` is ignored. After an accepted strobe at a clock edge, `line_out` carries the first half-bit from that edge and the second half-bit from the next edge. `bit_clk` is 1 exactly while the first half is on the line.
- R3: Code 0 (NRZ-L), and any undefined code 9 to 15, puts the data bit on the line for both halves.
- R4: Code 1 (NRZ-M) inverts the line for the whole bit when the data is 1 and holds it when the data is 0. Code 2 (NRZ-S) inverts the line when the data is 0 and holds it when the data is 1.
- R5: Code 3 (BIO-L) sends a 1 as high then low, and a 0 as low then high.
- R6: Code 4 (BIO-M) always inverts the line at the start of the bit, and inverts it again mid-bit when the data is 1. Code 5 (BIO-S) does the same, with the mid-bit inversion for a 0.
- R7: Code 6 (DM-M) inverts the line mid-bit for a 1. It inverts at the start of the bit when both the previous accepted bit and the current bit are 0.
- R8: Code 7 (DM-S) inverts the line mid-bit for a 0. It inverts at the start of the bit when both the previous accepted bit and the current bit are 1.
- R9: Code 8 (RNRZ-L) puts data XOR r on the line for both halves. The randomizer has 15 stages, s[14:0]. The value r is s[14] XOR s[13], which gives x^15+x^14+1. On every accepted bit, in every code, s shifts left with r entering at s[0].
- R10: Without an accepted strobe, the line holds its level and `bit_clk` stays 0.
- R11: `code_sel` is sampled only when a strobe is accepted. Changing it during a bit has no effect on the second half of that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Serial data bit, valid with `bit_stb` |
| bit_stb | input | 1 | One-clock pulse presenting a new bit |
| code_sel | input | 4 | Line code select, values 0 to 8 as listed in the requirements |
| line_out | output | 1 | Coded line signal |
| bit_clk | output | 1 | Bit-rate clock, high during the first half-bit |

## Verification
A wrong state or a lost half-bit shows on `bit_clk`, or as a line level that is off by half a bit, within two clocks of the strobe. A corrupted level history in the differential codes (M, S and DM) inverts every later level of the run, so it shows on the next bit. A stepping or seeding error in the randomizer shows as a wrong RNRZ-L level within a few bits, because runs longer than a dozen bits are compared.

Each code is swept after a fresh reset with the following patterns:
- all zeros
- all ones
- alternating bits
- a long fixed pseudo-random pattern with an idle gap

During each first half-bit, a spurious strobe with inverted data and a different code select is driven, so the ignored inputs are checked at the line on every bit.

// File: rtl/pcm_lc_pkg.sv
`timescale 1ns/1ps
package pcm_lc_pkg;

    localparam int CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        CODE_NRZ_L  = 4'd0,
        CODE_NRZ_M  = 4'd1,
        CODE_NRZ_S  = 4'd2,
        CODE_BIO_L  = 4'd3,
        CODE_BIO_M  = 4'd4,
        CODE_BIO_S  = 4'd5,
        CODE_DM_M   = 4'd6,
        CODE_DM_S   = 4'd7,
        CODE_RNRZ_L = 4'd8
    } line_code_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } half_state_e;

endpackage

// File: rtl/pcm_prbs.sv
`timescale 1ns/1ps
module pcm_prbs #(
    parameter int          LEN    = 15,
    parameter int          TAP_HI = 15,
    parameter int          TAP_LO = 14,
    parameter logic [14:0] SEED   = '1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    output logic rand_bit
);
    logic [LEN-1:0] lfsr_q;

    assign rand_bit = lfsr_q[TAP_HI-1] ^ lfsr_q[TAP_LO-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q <= SEED[LEN-1:0];
        end else if (advance) begin
            lfsr_q <= {lfsr_q[LEN-2:0], rand_bit};
        end
    end

    AST_PRBS_ALIVE: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0); // R9

endmodule

// File: rtl/pcm_half_levels.sv
`timescale 1ns/1ps
module pcm_half_levels
    import pcm_lc_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              data,
    input  logic              line_now,
    input  logic              prev_mark,
    input  logic              rand_bit,
    output logic              first_lvl,
    output logic              second_lvl,
    output logic              mark
);
    logic boundary;

    always_comb begin
        mark      = (code == CODE_DM_S) ? ~data : data;
        boundary  = ~prev_mark & ~mark;
        first_lvl  = data;
        second_lvl = data;
        case (code)
            CODE_NRZ_M: begin
                first_lvl  = line_now ^ data;
                second_lvl = first_lvl;
            end
            CODE_NRZ_S: begin
                first_lvl  = line_now ^ ~data;
                second_lvl = first_lvl;
            end
            CODE_BIO_L: begin
                first_lvl  = data;
                second_lvl = ~data;
            end
            CODE_BIO_M: begin
                first_lvl  = ~line_now;
                second_lvl = first_lvl ^ data;
            end
            CODE_BIO_S: begin
                first_lvl  = ~line_now;
                second_lvl = first_lvl ^ ~data;
            end
            CODE_DM_M, CODE_DM_S: begin
                first_lvl  = line_now ^ boundary;
                second_lvl = first_lvl ^ mark;
            end
            CODE_RNRZ_L: begin
                first_lvl  = data ^ rand_bit;
                second_lvl = first_lvl;
            end
            default: begin
                first_lvl  = data;
                second_lvl = data;
            end
        endcase
    end

endmodule

// File: rtl/pcm_line_encoder.sv
`timescale 1ns/1ps
module pcm_line_encoder
    import pcm_lc_pkg::*;
#(
    parameter int          PRBS_LEN  = 15,
    parameter int          PRBS_HI   = 15,
    parameter int          PRBS_LO   = 14,
    parameter logic [14:0] PRBS_SEED = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_stb,
    input  logic [CODE_W-1:0] code_sel,
    output logic              line_out,
    output logic              bit_clk
);
    half_state_e       state_q, state_d;
    logic              accept;
    logic              second_q;
    logic              prev_mark_q;
    logic [CODE_W-1:0] cur_code_q;
    logic              rand_bit;
    logic              first_lvl, second_lvl, mark;

    assign accept = bit_stb && (state_q != ST_FIRST);

    pcm_prbs #(
        .LEN   (PRBS_LEN),
        .TAP_HI(PRBS_HI),
        .TAP_LO(PRBS_LO),
        .SEED  (PRBS_SEED)
    ) i_prbs (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (accept),
        .rand_bit(rand_bit)
    );

    pcm_half_levels i_levels (
        .code      (code_sel),
        .data      (bit_in),
        .line_now  (line_out),
        .prev_mark (prev_mark_q),
        .rand_bit  (rand_bit),
        .first_lvl (first_lvl),
        .second_lvl(second_lvl),
        .mark      (mark)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = accept ? ST_FIRST : ST_IDLE;
            ST_FIRST:  state_d = ST_SECOND;
            ST_SECOND: state_d = accept ? ST_FIRST : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_out    <= 1'b0;
            second_q    <= 1'b0;
            prev_mark_q <= 1'b1;
            cur_code_q  <= CODE_NRZ_L;
        end else if (accept) begin
            line_out    <= first_lvl;
            second_q    <= second_lvl;
            prev_mark_q <= mark;
            cur_code_q  <= code_sel;
        end else if (state_q == ST_FIRST) begin
            line_out    <= second_q;
        end
    end

    assign bit_clk = (state_q == ST_FIRST);

    AST_HALF_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_FIRST |=> state_q == ST_SECOND); // R2

    AST_BITCLK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_clk |=> !bit_clk); // R2

    AST_LEVEL_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIRST && (cur_code_q == CODE_NRZ_L || cur_code_q == CODE_NRZ_M ||
         cur_code_q == CODE_NRZ_S || cur_code_q == CODE_RNRZ_L))
        |=> $stable(line_out)); // R3

    AST_BIO_L_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIRST && cur_code_q == CODE_BIO_L)
        |=> line_out != $past(line_out)); // R5

    AST_BIO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (code_sel == CODE_BIO_M || code_sel == CODE_BIO_S))
        |=> line_out != $past(line_out)); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_FIRST && !bit_stb) |=> $stable(line_out)); // R10

endmodule

// File: tb/test_pcm_line_encoder.sv
`timescale 1ns/1ps
module test_pcm_line_encoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b0;
    logic       bit_stb = 1'b0;
    logic [3:0] code_sel = 4'd0;
    logic       line_out;
    logic       bit_clk;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic        line_m;
    logic        prev_m;
    logic [14:0] prbs_m;

    always #2 clk = ~clk;

    pcm_line_encoder i_pcm_line_encoder (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_in  (bit_in),
        .bit_stb (bit_stb),
        .code_sel(code_sel),
        .line_out(line_out),
        .bit_clk (bit_clk)
    );

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bit_stb = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 line in reset", line_out, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 line after reset", line_out, 1'b0);
        check("R1 bit_clk after reset", bit_clk, 1'b0);
        line_m = 1'b0;
        prev_m = 1'b1;
        prbs_m = '1;
    endtask

    // Called at a falling edge; returns at a falling edge.
    task automatic send_bit(input logic d, input logic [3:0] code);
        logic f, s, mk, bnd, r;
        r = prbs_m[14] ^ prbs_m[13];
        mk = (code == 4'd7) ? ~d : d;
        bnd = ~prev_m & ~mk;
        case (code)
            4'd1: begin f = line_m ^ d;  s = f; end
            4'd2: begin f = line_m ^ ~d; s = f; end
            4'd3: begin f = d; s = ~d; end
            4'd4: begin f = ~line_m; s = f ^ d; end
            4'd5: begin f = ~line_m; s = f ^ ~d; end
            4'd6, 4'd7: begin f = line_m ^ bnd; s = f ^ mk; end
            4'd8: begin f = d ^ r; s = f; end
            default: begin f = d; s = d; end
        endcase
        prbs_m = {prbs_m[13:0], r};
        prev_m = mk;
        line_m = s;
        bit_stb = 1'b1;
        bit_in = d;
        code_sel = code;
        @(negedge clk);
        check($sformatf("R2 bit_clk first half code %0d", code), bit_clk, 1'b1);
        check($sformatf("R3-code%0d first half (R4 R5 R6 R7 R8 R9)", code), line_out, f);
        // spurious strobe and code change during the first half: R2, R11
        bit_in = ~d;
        code_sel = code ^ 4'd3;
        @(negedge clk);
        check($sformatf("R2 bit_clk second half code %0d", code), bit_clk, 1'b0);
        check($sformatf("R11 second half code %0d", code), line_out, s);
        bit_stb = 1'b0;
        code_sel = code;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R10 idle line", line_out, line_m);
            check("R10 idle bit_clk", bit_clk, 1'b0);
        end
    endtask

    task automatic sweep(input logic [3:0] code);
        logic [31:0] pat;
        do_reset();
        for (int i = 0; i < 6; i++) send_bit(1'b0, code);
        for (int i = 0; i < 6; i++) send_bit(1'b1, code);
        for (int i = 0; i < 8; i++) send_bit(i[0], code);
        pat = 32'hB53C_96E1;
        for (int i = 0; i < 16; i++) send_bit(pat[i], code);
        idle(3);
        for (int i = 16; i < 32; i++) send_bit(pat[i], code);
        idle(2);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        line_m = 1'b0;
        prev_m = 1'b1;
        prbs_m = '1;
        repeat (2) @(negedge clk);
        // R3 NRZ-L, R4 NRZ-M/S, R5 BIO-L, R6 BIO-M/S, R7 DM-M, R8 DM-S, R9 RNRZ-L
        for (int c = 0; c <= 8; c++) sweep(c[3:0]);
        sweep(4'd12); // R3 undefined code
        sweep(4'd15); // R3 undefined code
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule